// File: doc/BRIEF.md
# External Interrupt Request Latch Unit

This block watches a set of asynchronous input pins, one per channel, and turns activity on them into held request flags. Each pin is brought into the clock domain through a short synchronizer chain. A two-bit setting per channel then chooses what counts as an event: a low level, a high level, a rising edge or a falling edge. An event sets the channel's flag, and the flag stays set until software clears it. This holds in the level settings too, so removing the external cause never drops a pending request.

A per-channel enable gates each flag onto a registered interrupt-controller request line. A separate per-channel select sends the gated flag to a transfer-request line instead. A transfer engine acknowledges it with a one-cycle service pulse. The pulse clears the flag and starts a short hold timer. When the timer runs out, the pin is sampled again. If the device has not withdrawn its request by then, a new request is raised. Software reaches the flags and settings through a small word-wide register port with registered read data.

Top module: `extirq_latch`

## Requirements
- R1: After synchronous reset, the flag, enable, mode and transfer-select registers all read 0, and `irq_o` and `xfer_o` are 0. With every pin held high, no flag is set as the unit leaves reset.
- R2: Mode field of channel c is `reg_mode[2c+1:2c]`: 00 low level, 01 high level, 10 rising edge, 11 falling edge. In the edge settings, only a transition of the synchronized pin sets the flag. A level held after the flag has been cleared does not set it again.
- R3: In the level settings, the active level sets the flag. The flag stays set after the pin returns to its inactive level. A clear written while the level is still active does not remove the flag.
- R4: For a channel whose transfer-select bit is 0, `irq_o` bit c is the registered AND of flag c and enable c. It stays asserted whatever the pin does, until the flag or the enable is cleared.
- R5: Writing address 0 clears every flag whose data bit is 0. Data bits that are 1 leave their flags unchanged. An event in the same cycle as a clear wins, so the flag stays set.
- R6: For a channel whose transfer-select bit is 1, the gated flag drives `xfer_o` bit c, and `irq_o` bit c stays 0. A service pulse on a channel whose select bit is 0 has no effect.
- R7: A service pulse on a transfer-selected channel clears its flag, so the `xfer_o` bit drops one cycle later. Three clocks after the pulse, the synchronized pin is sampled again. If it is at the channel's active level (low for 00 and 11, high for 01 and 10), the flag is set again.
- R8: Register addresses are 0 for flags, 1 for enables, 2 for modes and 3 for transfer selects. Read data appears one clock after the address is presented. Bits above a register's width read as 0.
- R9: In the edge settings, a pulse lasting three clocks sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NCH | Asynchronous request pins, one per channel |
| svc_i | input | NCH | One-cycle service-start pulses from the transfer engine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*NCH | Register write data |
| reg_rdata | output | 2*NCH | Registered read data |
| irq_o | output | NCH | Interrupt-controller requests (registered) |
| xfer_o | output | NCH | Transfer requests (registered) |

## Verification
Every channel is tried in each of the four detection settings. Each trial applies the same pattern: the idle level, then a held active level, a clear while the pin is still active, a return to idle, and a three-clock pulse. Level and edge settings part ways on the clear while active and on the return to idle, so this pattern separates them. The enable alternates by channel, which shows whether the interrupt line follows the held flag and the enable rather than the pin. Transfer channels are serviced twice: once with the line withdrawn together with the pulse, and once with it left active. This separates a completed service from a fresh request.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;

  localparam logic [1:0] ADR_FLAG = 2'd0;
  localparam logic [1:0] ADR_EN   = 2'd1;
  localparam logic [1:0] ADR_MODE = 2'd2;
  localparam logic [1:0] ADR_XSEL = 2'd3;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int         W       = 8,
  parameter int         STAGES  = 2,
  parameter logic       RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
  import extirq_pkg::*;
#(
  parameter int HOLD = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s,
  input  logic [1:0] mode,
  input  logic       xsel,
  input  logic       svc,
  input  logic       clr,
  output logic       flag
);
  localparam int TW = $clog2(HOLD + 1);

  logic          prev;
  logic [TW-1:0] tmr;
  logic          ev;
  logic          lvl_act;

  // Active level: high for 01/10, low for 00/11.
  assign lvl_act = s ^ (mode[1] ~^ mode[0]);

  always_comb begin
    unique case (det_mode_e'(mode))
      DET_LOW:  ev = ~s;
      DET_HIGH: ev = s;
      DET_RISE: ev = s & ~prev;
      DET_FALL: ev = ~s & prev;
      default:  ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b1;
      flag <= 1'b0;
      tmr  <= '0;
    end else begin
      prev <= s;
      if (svc && xsel) begin
        flag <= 1'b0;
        tmr  <= TW'(HOLD);
      end else if (tmr != '0) begin
        tmr  <= tmr - TW'(1);
        flag <= ((tmr == TW'(1)) && lvl_act) | (flag & ~clr);
      end else begin
        flag <= (flag & ~clr) | ev;
      end
    end
  end
endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
  import extirq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int SYNC_N = 2,
  parameter int HOLD   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pin_i,
  input  logic [NCH-1:0]   svc_i,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [2*NCH-1:0] reg_wdata,
  output logic [2*NCH-1:0] reg_rdata,
  output logic [NCH-1:0]   irq_o,
  output logic [NCH-1:0]   xfer_o
);
  localparam int DW = 2 * NCH;

  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] xsel_q;
  logic [DW-1:0]  mode_q;
  logic [NCH-1:0] clr;

  extirq_sync #(.W(NCH), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pin_s)
  );

  assign clr = (reg_wr && reg_addr == ADR_FLAG) ? ~reg_wdata[NCH-1:0] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    extirq_chan #(.HOLD(HOLD)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .s    (pin_s[c]),
      .mode (mode_q[2*c +: 2]),
      .xsel (xsel_q[c]),
      .svc  (svc_i[c]),
      .clr  (clr[c]),
      .flag (flag_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      xsel_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_EN:   en_q   <= reg_wdata[NCH-1:0];
        ADR_MODE: mode_q <= reg_wdata;
        ADR_XSEL: xsel_q <= reg_wdata[NCH-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= '0;
      xfer_o    <= '0;
    end else begin
      irq_o  <= flag_q & en_q & ~xsel_q;
      xfer_o <= flag_q & en_q & xsel_q;
      case (reg_addr)
        ADR_FLAG: reg_rdata <= {{(DW-NCH){1'b0}}, flag_q};
        ADR_EN:   reg_rdata <= {{(DW-NCH){1'b0}}, en_q};
        ADR_MODE: reg_rdata <= mode_q;
        default:  reg_rdata <= {{(DW-NCH){1'b0}}, xsel_q};
      endcase
    end
  end
endmodule

// File: rtl/extirq_latch_chk.sv
module extirq_latch_chk #(
  parameter int NCH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [2*NCH-1:0] reg_wdata,
  input logic [NCH-1:0]   svc_i,
  input logic [NCH-1:0]   irq_o,
  input logic [NCH-1:0]   xfer_o,
  input logic [NCH-1:0]   flag_q,
  input logic [NCH-1:0]   en_q,
  input logic [NCH-1:0]   xsel_q
);
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (rst)
    (irq_o & xfer_o) == '0); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq_o & ~$past(en_q)) == '0); // R4

  AST_XFER_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (xfer_o & ~$past(xsel_q)) == '0); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && svc_i == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R3

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[NCH-1:0] == '1 && svc_i == '0)
      |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R5

  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((svc_i & xsel_q) != '0) |=> ((flag_q & $past(svc_i & xsel_q)) == '0)); // R7
endmodule

bind extirq_latch extirq_latch_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .svc_i     (svc_i),
  .irq_o     (irq_o),
  .xfer_o    (xfer_o),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .xsel_q    (xsel_q)
);

// File: tb/sim_extirq_latch.sv
module sim_extirq_latch;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 2 * NCH;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pin = '1;
  logic [NCH-1:0] svc = '0;
  logic           wr  = 1'b0;
  logic [1:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] irq;
  logic [NCH-1:0] xfer;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  extirq_latch #(.NCH(NCH), .SYNC_N(2), .HOLD(3)) u0 (
    .clk (clk), .rst (rst), .pin_i (pin), .svc_i (svc),
    .reg_wr (wr), .reg_addr (addr), .reg_wdata (wdata),
    .reg_rdata (rdata), .irq_o (irq), .xfer_o (xfer)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    rv = rdata;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(6);
    // R1 reset state
    rreg(2'd0); chk("R1 flags", rv, '0);
    rreg(2'd1); chk("R1 enables", rv, '0);
    rreg(2'd2); chk("R1 modes", rv, '0);
    rreg(2'd3); chk("R1 xsel", rv, '0);
    chk("R1 irq", DW'(irq), '0);
    chk("R1 xfer", DW'(xfer), '0);

    // Sweep: every channel, every detection setting
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic idle;
        logic lvl;
        logic [NCH-1:0] bitm;
        logic [NCH-1:0] en;
        idle = (m == 0 || m == 3);
        lvl  = (m < 2);
        bitm = NCH'(1) << ch;
        en   = ((ch + m) % 2 == 0) ? bitm : '0;
        wreg(2'd1, DW'(en));
        wreg(2'd2, DW'(m) << (2*ch));
        pin[ch] = idle;
        cyc(6);
        wreg(2'd0, '0);
        cyc(4);
        rreg(2'd0); chk("R2 idle no event", rv, '0);
        chk("R4 idle irq", DW'(irq), '0);

        pin[ch] = ~idle;
        cyc(6);
        rreg(2'd0); chk(lvl ? "R3 level sets" : "R2 edge sets", rv, DW'(bitm));
        chk("R4 gated irq", DW'(irq), DW'(en));

        wreg(2'd0, '0);
        cyc(4);
        rreg(2'd0);
        chk(lvl ? "R5 event beats clear" : "R2 held level no retrigger", rv, lvl ? DW'(bitm) : '0);

        pin[ch] = idle;
        cyc(6);
        rreg(2'd0); chk(lvl ? "R3 sticky after idle" : "R2 return no event", rv, lvl ? DW'(bitm) : '0);
        chk("R4 irq held vs pin", DW'(irq), lvl ? DW'(en) : '0);

        wreg(2'd0, '0);
        cyc(2);
        pin[ch] = ~idle;
        cyc(3);
        pin[ch] = idle;
        cyc(6);
        rreg(2'd0); chk("R9 three clock pulse", rv, DW'(bitm));

        wreg(2'd0, {DW{1'b1}});
        cyc(3);
        rreg(2'd0); chk("R5 write one keeps", rv, DW'(bitm));
        wreg(2'd0, '0);
        cyc(3);
        rreg(2'd0); chk("R5 write zero clears", rv, '0);
        chk("R4 irq drops", DW'(irq), '0);

        rreg(2'd2); chk("R8 mode readback", rv, DW'(m) << (2*ch));
        pin[ch] = 1'b1;
        wreg(2'd2, '0);
        cyc(2);
      end
    end

    // Transfer mode: channel 2 high level, channel 0 low-level interrupt
    wreg(2'd0, '0);
    wreg(2'd2, DW'(16'h0010));
    wreg(2'd3, DW'(8'h04));
    wreg(2'd1, DW'(8'h05));
    pin = 8'hFB;
    cyc(6);
    wreg(2'd0, '0);
    cyc(4);
    rreg(2'd0); chk("R6 clean start", rv, '0);

    pin[2] = 1'b1;
    cyc(6);
    chk("R6 xfer raised", DW'(xfer), DW'(8'h04));
    chk("R6 no irq for xfer ch", DW'(irq), '0);

    @(negedge clk); svc = 8'h04; pin[2] = 1'b0;
    @(negedge clk); svc = '0;
    cyc(8);
    rreg(2'd0); chk("R7 serviced flag cleared", rv, '0);
    chk("R7 xfer low after service", DW'(xfer), '0);

    pin[2] = 1'b1;
    cyc(6);
    chk("R6 xfer again", DW'(xfer), DW'(8'h04));
    @(negedge clk); svc = 8'h04;
    @(negedge clk); svc = '0;
    @(negedge clk);
    chk("R7 xfer drops after pulse", DW'(xfer), '0);
    cyc(4);
    chk("R7 still active re-request", DW'(xfer), DW'(8'h04));
    rreg(2'd0); chk("R7 flag set again", rv, DW'(8'h04));

    pin[0] = 1'b0;
    cyc(6);
    pin[0] = 1'b1;
    cyc(6);
    chk("R4 irq ch0", DW'(irq), DW'(8'h01));
    @(negedge clk); svc = 8'h01;
    @(negedge clk); svc = '0;
    cyc(5);
    chk("R6 service ignored on irq ch", DW'(irq), DW'(8'h01));

    rreg(2'd1); chk("R8 enable readback", rv, DW'(8'h05));
    rreg(2'd3); chk("R8 xsel readback", rv, DW'(8'h04));
    rreg(2'd2); chk("R8 mode readback", rv, DW'(16'h0010));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule